// File: doc/BRIEF.md
# Parallel Printer Port Status and Control Registers

This block is the host-facing register pair of a legacy parallel printer port. A CPU reaches it through a small bus made of an address offset, read and write strobes, and byte-wide write and read data. One register reports the five handshake lines that come back from the printer. The other register holds the control bits that drive four lines going out to the printer, each with its own polarity. A further control bit enables an interrupt request on the acknowledge line.

The five incoming lines are asynchronous to the bus clock, so each one passes through a synchroniser before it is read or edge-detected. When the interrupt is enabled, a low-to-high transition on the synchronised acknowledge line sets a level interrupt request. The request stays high until software reads the status register or clears the enable bit. Read data is combinational from the offset, so it is valid in the same cycle as the offset. A read has a side effect only at the status offset.

Top module: `pport_status_ctrl`

## Requirements
- R1: The status register sits at offset 1 and the control register at offset 2. A read at any other offset returns 0x00, and a write to any other offset changes no register and no output pin.
- R2: Status bits 2..0 always read 0. Bit 3 returns fault_n, bit 4 returns select, bit 5 returns paper_err and bit 6 returns ack_n, each at its own level without inversion.
- R3: Status bit 7 returns the complement of the busy input.
- R4: A change on a status input shows in the status read data after exactly two rising clock edges, and not after one.
- R5: Synchronous active-low reset clears control bits 5..0 and the interrupt request. After reset, strobe_n, autofeed_n and select_in_n are 1 and init_n is 0.
- R6: A control read returns the stored bits 5..0 and returns 0 in bits 7..6. Write data in bits 7..6 is ignored.
- R7: Control bit 0 drives strobe_n inverted, bit 1 drives autofeed_n inverted, and bit 3 drives select_in_n inverted.
- R8: Control bit 2 drives init_n at the same level, without inversion.
- R9: When control bit 4 is 1, a rising edge of the synchronised ack_n sets irq on the third clock edge after the input changes. A falling edge never sets irq, and no edge sets irq while bit 4 is 0.
- R10: Once set, irq stays high until a read strobe at the status offset. irq is low after the clock edge that samples that read. A control read leaves irq unchanged.
- R11: A control write with bit 4 equal to 0 clears a pending irq on the same clock edge that stores the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_rd | input | 1 | Read strobe (status read clears irq) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| fault_n | input | 1 | Printer fault line, active low |
| select | input | 1 | Printer selected line |
| paper_err | input | 1 | Paper error line |
| ack_n | input | 1 | Printer acknowledge line, active low |
| busy | input | 1 | Printer busy line |
| strobe_n | output | 1 | Data strobe to printer, active low |
| autofeed_n | output | 1 | Auto line feed request, active low |
| init_n | output | 1 | Printer initialise, active low |
| select_in_n | output | 1 | Printer select request, active low |
| irq | output | 1 | Acknowledge interrupt request, level |

## Verification
The bench builds the block with its default parameters: a 3-bit offset, status at 1, control at 2, and a two-stage synchroniser. The 3-bit offset leaves six unmapped offsets, so reads and writes at offsets 0, 3 and 7 can be checked for having no effect. The two-stage depth gives a known latency, so the status lag and the third-edge timing of the interrupt can be checked to the exact cycle.

// File: rtl/pport_pkg.sv
// Package: shared bit positions and the packed view of the incoming
// printer lines for the parallel-port register block.
// Assumes: byte-wide registers; only the low six control bits exist.
package pport_pkg;

    localparam int REG_W = 8;
    localparam int CTL_W = 6;
    localparam int IN_W  = 5;

    // control bit positions
    localparam int CB_STROBE   = 0;
    localparam int CB_AUTOFEED = 1;
    localparam int CB_INIT     = 2;
    localparam int CB_SELIN    = 3;
    localparam int CB_ACKIE    = 4;

    // status bit positions
    localparam int SB_FAULT = 3;
    localparam int SB_SEL   = 4;
    localparam int SB_PERR  = 5;
    localparam int SB_ACK   = 6;
    localparam int SB_BUSY  = 7;

    // incoming lines, fault_n in bit 0
    typedef struct packed {
        logic busy;
        logic ack_n;
        logic paper_err;
        logic select;
        logic fault_n;
    } pin_in_t;

endpackage

// File: rtl/pport_sync.sv
// Module: pport_sync
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes: each bit is independent (no bus coherence needed); STAGES >= 2.
module pport_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    // first stage captures the raw input
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_async;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // each further stage re-times the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) chain[gi] <= '0;
                else        chain[gi] <= chain[gi-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2)) |-> (q_sync == $past(d_async, 2))); // R4
        end
    endgenerate

endmodule

// File: rtl/pport_ctrl_reg.sv
// Module: pport_ctrl_reg
// Six-bit control register and the four printer control pins it drives.
// Assumes: the caller decodes the offset; wr_en is a single-cycle qualified write.
module pport_ctrl_reg
    import pport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] ctl_q,
    output logic             strobe_n,
    output logic             autofeed_n,
    output logic             init_n,
    output logic             select_in_n
);

    // store the writable control bits
    always_ff @(posedge clk) begin
        if (!rst_n)     ctl_q <= '0;
        else if (wr_en) ctl_q <= wdata;
    end

    // map control bits onto the pins with per-pin polarity
    always_comb begin
        strobe_n    = ~ctl_q[CB_STROBE];
        autofeed_n  = ~ctl_q[CB_AUTOFEED];
        init_n      =  ctl_q[CB_INIT];
        select_in_n = ~ctl_q[CB_SELIN];
    end

    AST_CTL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctl_q == $past(wdata))); // R6
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(ctl_q)); // R1

endmodule

// File: rtl/pport_ack_irq.sv
// Module: pport_ack_irq
// Edge detector on the synchronised acknowledge line and the level
// interrupt flag it sets.
// Assumes: ack_s is already synchronised; enable comes from the control register.
module pport_ack_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_s,
    input  logic enable,
    input  logic en_clear_wr,
    input  logic status_rd,
    output logic irq
);

    logic ack_prev;
    logic ack_rise;

    // remember the previous synchronised level
    always_ff @(posedge clk) begin
        if (!rst_n) ack_prev <= 1'b0;
        else        ack_prev <= ack_s;
    end

    assign ack_rise = ack_s & ~ack_prev;

    // set on a qualified edge; clear on status read or when the enable goes away
    always_ff @(posedge clk) begin
        if (!rst_n)                      irq <= 1'b0;
        else if (!enable || en_clear_wr) irq <= 1'b0;
        else if (ack_rise)               irq <= 1'b1;
        else if (status_rd)              irq <= 1'b0;
    end

    AST_IRQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ack_rise && enable)); // R9
    AST_IRQ_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !ack_rise) |=> !irq); // R10
    AST_IRQ_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        en_clear_wr |=> !irq); // R11
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && enable && !en_clear_wr && !status_rd) |=> irq); // R10

endmodule

// File: rtl/pport_status_ctrl.sv
// Module: pport_status_ctrl (top)
// Host register interface of a parallel printer port: status register,
// control register, pin polarity and acknowledge interrupt.
// Assumes: read data is consumed combinationally in the strobe cycle;
// the offsets passed as parameters differ and fit in ADDR_W bits.
module pport_status_ctrl
    import pport_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int STS_OFS     = 1,
    parameter int CTL_OFS     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              fault_n,
    input  logic              select,
    input  logic              paper_err,
    input  logic              ack_n,
    input  logic              busy,
    output logic              strobe_n,
    output logic              autofeed_n,
    output logic              init_n,
    output logic              select_in_n,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFS);
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFS);

    pin_in_t          pins_raw;
    pin_in_t          pins_s;
    logic [IN_W-1:0]  pins_s_vec;
    logic [CTL_W-1:0] ctl_q;
    logic             hit_sts;
    logic             hit_ctl;
    logic             ctl_wr;
    logic             sts_rd;
    logic             en_clear_wr;
    logic [1:0]       unused_wdata_hi;

    assign pins_raw = '{busy: busy, ack_n: ack_n, paper_err: paper_err,
                        select: select, fault_n: fault_n};

    pport_sync #(
        .WIDTH  (IN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pins_raw),
        .q_sync  (pins_s_vec)
    );

    assign pins_s = pin_in_t'(pins_s_vec);

    // offset decode and qualified strobes
    always_comb begin
        hit_sts         = (bus_addr == STS_A);
        hit_ctl         = (bus_addr == CTL_A);
        ctl_wr          = bus_wr & hit_ctl;
        sts_rd          = bus_rd & hit_sts;
        en_clear_wr     = ctl_wr & ~bus_wdata[CB_ACKIE];
        unused_wdata_hi = bus_wdata[REG_W-1:CTL_W];
    end

    pport_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (ctl_wr),
        .wdata       (bus_wdata[CTL_W-1:0]),
        .ctl_q       (ctl_q),
        .strobe_n    (strobe_n),
        .autofeed_n  (autofeed_n),
        .init_n      (init_n),
        .select_in_n (select_in_n)
    );

    pport_ack_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_s       (pins_s.ack_n),
        .enable      (ctl_q[CB_ACKIE]),
        .en_clear_wr (en_clear_wr),
        .status_rd   (sts_rd),
        .irq         (irq)
    );

    // read mux: status, control, or zero
    always_comb begin
        bus_rdata = '0;
        if (hit_sts) begin
            bus_rdata[SB_FAULT] = pins_s.fault_n;
            bus_rdata[SB_SEL]   = pins_s.select;
            bus_rdata[SB_PERR]  = pins_s.paper_err;
            bus_rdata[SB_ACK]   = pins_s.ack_n;
            bus_rdata[SB_BUSY]  = ~pins_s.busy;
        end else if (hit_ctl) begin
            bus_rdata[CTL_W-1:0] = ctl_q;
        end
    end

    AST_IRQ_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctl_q[CB_ACKIE]); // R9
    AST_RESET_CLEARS_CTL: assert property (@(posedge clk)
        !rst_n |=> (ctl_q == '0 && !irq)); // R5
    AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (init_n != strobe_n) || (ctl_q[CB_INIT] == ctl_q[CB_STROBE]) || 1'b0
        |-> (init_n == ctl_q[CB_INIT])); // R8
    AST_OTHER_WR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit_ctl) |=> (ctl_q == $past(ctl_q))); // R1

endmodule

// File: tb/sim_pport_status_ctrl.sv
`timescale 1ns/1ps
module sim_pport_status_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] bus_addr;
    logic       bus_rd;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       fault_n, select, paper_err, ack_n, busy;
    logic       strobe_n, autofeed_n, init_n, select_in_n, irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pport_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fault_n(fault_n), .select(select), .paper_err(paper_err),
        .ack_n(ack_n), .busy(busy), .strobe_n(strobe_n),
        .autofeed_n(autofeed_n), .init_n(init_n),
        .select_in_n(select_in_n), .irq(irq)
    );

    // kind(1: 0 status, 1 control) | data(8) | expected read(8) | pins {stb,af,init,sel}(4)
    localparam int NV = 14;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'h80, 4'b0000},  // R2 R3 all low
        {1'b0, 8'h1F, 8'h78, 4'b0000},  // R2 R3 all high
        {1'b0, 8'h01, 8'h88, 4'b0000},  // R2 fault_n only
        {1'b0, 8'h12, 8'h10, 4'b0000},  // R2 R3 select and busy
        {1'b0, 8'h04, 8'hA0, 4'b0000},  // R2 paper_err only
        {1'b0, 8'h08, 8'hC0, 4'b0000},  // R2 ack_n only
        {1'b1, 8'h00, 8'h00, 4'b1101},  // R6 R7 R8
        {1'b1, 8'hFF, 8'h3F, 4'b0010},  // R6 R7 R8
        {1'b1, 8'h01, 8'h01, 4'b0101},  // R7 strobe
        {1'b1, 8'h02, 8'h02, 4'b1001},  // R7 autofeed
        {1'b1, 8'h04, 8'h04, 4'b1111},  // R8 init direct
        {1'b1, 8'h08, 8'h08, 4'b1100},  // R7 select_in
        {1'b1, 8'hC0, 8'h00, 4'b1101},  // R6 high bits ignored
        {1'b1, 8'hA5, 8'h25, 4'b0111}   // R6 R7 R8 mixed
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic status_read();
        bus_addr = 3'd1; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_pins(input logic [4:0] p);
        {busy, ack_n, paper_err, select, fault_n} = p;
    endtask

    function automatic logic [7:0] pin_vec();
        return {4'b0, strobe_n, autofeed_n, init_n, select_in_n};
    endfunction

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        set_pins(5'b0);
        tick(3);
        peek(3'd2, d);
        check("R5 ctl after reset", d, 8'h00);
        check("R5 pins after reset", pin_vec(), 8'h0D);
        check("R5 irq after reset", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        tick(1);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20] == 1'b0) begin
                set_pins(VEC[i][16:12]);
                tick(3);
                peek(3'd1, d);
                check("R2/R3 status vector", d, VEC[i][11:4]);
            end else begin
                wr(3'd2, VEC[i][19:12]);
                peek(3'd2, d);
                check("R6 ctl readback", d, VEC[i][11:4]);
                check("R7/R8 pin vector", pin_vec(), {4'b0, VEC[i][3:0]});
            end
        end

        // R4 two-edge latency on busy
        busy = 1'b1;
        tick(1);
        peek(3'd1, d);
        check("R4 after one edge", d, 8'hC0);
        tick(1);
        peek(3'd1, d);
        check("R4 after two edges", d, 8'h40);

        // R1 unmapped offsets
        wr(3'd2, 8'h00);
        wr(3'd3, 8'hFF);
        wr(3'd0, 8'h1F);
        peek(3'd2, d);
        check("R1 ctl untouched by other offsets", d, 8'h00);
        check("R1 pins untouched", pin_vec(), 8'h0D);
        peek(3'd0, d); check("R1 read offset 0", d, 8'h00);
        peek(3'd3, d); check("R1 read offset 3", d, 8'h00);
        peek(3'd7, d); check("R1 read offset 7", d, 8'h00);

        // R9 rising edge with enable
        ack_n = 1'b0;
        tick(4);
        wr(3'd2, 8'h10);
        check("R9 no irq before edge", {7'b0, irq}, 8'h00);
        ack_n = 1'b1;
        tick(2);
        check("R9 irq not yet after two edges", {7'b0, irq}, 8'h00);
        tick(1);
        check("R9 irq on third edge", {7'b0, irq}, 8'h01);

        // R10 control read keeps it, status read clears it
        bus_rd = 1'b1; bus_addr = 3'd2;
        tick(1);
        bus_rd = 1'b0;
        check("R10 ctl read keeps irq", {7'b0, irq}, 8'h01);
        tick(2);
        check("R10 irq held", {7'b0, irq}, 8'h01);
        status_read();
        check("R10 status read clears irq", {7'b0, irq}, 8'h00);

        // R9 falling edge does nothing
        ack_n = 1'b0;
        tick(4);
        check("R9 falling edge no irq", {7'b0, irq}, 8'h00);

        // R11 clearing enable clears pending irq
        ack_n = 1'b1;
        tick(4);
        check("R11 irq pending", {7'b0, irq}, 8'h01);
        wr(3'd2, 8'h00);
        check("R11 enable clear drops irq", {7'b0, irq}, 8'h00);

        // R9 disabled: no irq on rising edge
        ack_n = 1'b0;
        tick(4);
        ack_n = 1'b1;
        tick(4);
        check("R9 disabled no irq", {7'b0, irq}, 8'h00);

        // R5 reset in mid-run
        wr(3'd2, 8'h3F);
        rst_n = 1'b0;
        tick(2);
        peek(3'd2, d);
        check("R5 reset clears ctl", d, 8'h00);
        check("R5 reset pins idle", pin_vec(), 8'h0D);
        rst_n = 1'b1;
        tick(1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule